// File: doc/BRIEF.md
# I2C Target with Auto-Incrementing Register Pointer

This block is a bus target for a two-wire serial bus. It sits behind open-drain pads and sees the clock and data lines as plain inputs. It pulls the data line low through a single drive-enable output. A fixed 7-bit device address is set by a parameter. Behind it sits a small register file, read and written over the bus through an internal pointer.

A master writes by addressing the target. The first data byte sets the pointer, and each later byte goes into the register the pointer names, after which the pointer steps on. To read, the master addresses the target with the read flag set and clocks out bytes, starting at the current pointer. The pointer survives a repeated START and a STOP. This gives the usual sequence: write the pointer, issue a repeated START, then read from that register. Both bus lines are resynchronised to the system clock. START, STOP and the SCL edges are found from the resynchronised samples.

Top module: `i2c_ptr_target`

## Requirements
- R1: After reset `sda_oe_o` is 0 and the pointer is 0. Register i holds `RST_BASE + i`, which is 0x50 + i by default, for i = 0 to NREGS-1.
- R2: A START is a falling SDA while SCL is high. A STOP is a rising SDA while SCL is high. A STOP sends the target to idle, and bytes clocked after it without a new START get no acknowledge and no drive.
- R3: The address byte is taken MSB first, with bits [7:1] as the address and bit 0 as the direction (1 = read). If the address equals DEV_ADDR the target holds SDA low for the whole 9th clock. Any other address gets no drive until the next START.
- R4: Addresses 0x78 to 0x7F are never acknowledged.
- R5: Address 0x00 with the write flag is acknowledged, and so are its data bytes. These bytes change neither the register file nor the pointer. Address 0x00 with the read flag gets no acknowledge.
- R6: In a write, the target acknowledges every data byte. The first data byte loads the pointer from its low log2(NREGS) bits. Each later byte is stored at the pointer, and the pointer then increments, wrapping from NREGS-1 to 0.
- R7: In a read, the target starts driving the MSB of the byte at the pointer at the SCL fall that ends the address ACK. It drives SDA low for a 0 bit and releases it for a 1 bit. It releases SDA during the master's ACK slot. The pointer increments once per byte sent.
- R8: If the master drives ACK (SDA low) in the 9th clock of a read byte, the next register is sent. If the master leaves NACK (SDA high), the target releases SDA and drives nothing until a START or STOP.
- R9: A repeated START restarts address reception with no STOP in between. The pointer value is kept.
- R10: `sda_oe_o` changes only while SCL is low. A change appears three system clocks after the SCL fall reaches the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
Two things happen together on the same SCL fall. The stored byte is written at the pointer while the pointer advances. In a read, the register at the pointer is fetched into the shift register while the pointer is bumped. The bench provokes this with consecutive writes that straddle the wrap from the last register to register 0. It then reads back across the same boundary after a repeated START, and judges the order of the returned bytes against a behavioural register array and pointer of its own. The drive-enable is compared on every clock with an expected level derived from bus phase, so a fetch or store made one register off shows up as a wrong bit.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WBYTE,
    ST_WACK,
    ST_RBYTE,
    ST_RACK,
    ST_PARK
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_linesync.sv
module i2c_tgt_linesync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_pipe[STAGES-1];
      sda_q <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_tgt_regfile.sv
module i2c_tgt_regfile #(
  parameter int          NREGS    = 8,
  parameter logic [7:0]  RST_BASE = 8'h50,
  localparam int         AW       = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem_q [NREGS];

  generate
    for (genvar i = 0; i < NREGS; i++) begin : g_reg
      logic hit;
      assign hit = we && (addr == AW'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mem_q[i] <= RST_BASE + 8'(i);
        end else if (hit) begin
          mem_q[i] <= wdata;
        end
      end
    end
  endgenerate

  assign rdata = mem_q[addr];
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h3A,
  parameter int         AW       = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    rd_data,
  output logic          reg_we,
  output logic [AW-1:0] reg_addr,
  output logic [7:0]    reg_wdata,
  output logic          sda_oe
);
  tgt_state_e    state_q, state_d;
  logic [3:0]    cnt_q, cnt_d;
  logic [7:0]    rx_q, rx_d;
  logic [7:0]    tx_q, tx_d;
  logic          rw_q, rw_d;
  logic          gc_q, gc_d;
  logic          first_q, first_d;
  logic          mack_q, mack_d;
  logic [AW-1:0] ptr_q, ptr_d;

  logic [6:0]    rx_addr;
  logic          hit_dev;
  logic          hit_gc;
  logic          byte_end;

  assign rx_addr  = rx_q[7:1];
  assign hit_dev  = (rx_addr == DEV_ADDR) && (rx_addr[6:3] != 4'hF);
  assign hit_gc   = (rx_addr == 7'h00) && !rx_q[0];
  assign byte_end = scl_fall && (cnt_q == 4'd8);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rx_d    = rx_q;
    tx_d    = tx_q;
    rw_d    = rw_q;
    gc_d    = gc_q;
    first_d = first_q;
    mack_d  = mack_q;
    ptr_d   = ptr_q;
    reg_we  = 1'b0;

    if (stop_det) begin
      state_d = ST_IDLE;
    end else if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = 4'd0;
    end else begin
      case (state_q)
        ST_ADDR: begin
          if (scl_rise) begin
            rx_d  = {rx_q[6:0], sda_s};
            cnt_d = cnt_q + 4'd1;
          end
          if (byte_end) begin
            if (hit_dev || hit_gc) begin
              state_d = ST_AACK;
              rw_d    = rx_q[0];
              gc_d    = hit_gc;
              first_d = 1'b1;
            end else begin
              state_d = ST_PARK;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            cnt_d = 4'd0;
            if (rw_q) begin
              state_d = ST_RBYTE;
              tx_d    = rd_data;
              ptr_d   = ptr_q + 1'b1;
            end else begin
              state_d = ST_WBYTE;
            end
          end
        end
        ST_WBYTE: begin
          if (scl_rise) begin
            rx_d  = {rx_q[6:0], sda_s};
            cnt_d = cnt_q + 4'd1;
          end
          if (byte_end) begin
            state_d = ST_WACK;
            if (!gc_q) begin
              if (first_q) begin
                ptr_d   = rx_q[AW-1:0];
                first_d = 1'b0;
              end else begin
                reg_we = 1'b1;
                ptr_d  = ptr_q + 1'b1;
              end
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            cnt_d   = 4'd0;
            state_d = ST_WBYTE;
          end
        end
        ST_RBYTE: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 4'd1;
          end
          if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              state_d = ST_RACK;
            end else begin
              tx_d = {tx_q[6:0], 1'b0};
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end
          if (scl_fall) begin
            if (mack_q) begin
              state_d = ST_RBYTE;
              cnt_d   = 4'd0;
              tx_d    = rd_data;
              ptr_d   = ptr_q + 1'b1;
            end else begin
              state_d = ST_PARK;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= 4'd0;
      rx_q    <= 8'h00;
      tx_q    <= 8'h00;
      rw_q    <= 1'b0;
      gc_q    <= 1'b0;
      first_q <= 1'b0;
      mack_q  <= 1'b0;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rx_q    <= rx_d;
      tx_q    <= tx_d;
      rw_q    <= rw_d;
      gc_q    <= gc_d;
      first_q <= first_d;
      mack_q  <= mack_d;
      ptr_q   <= ptr_d;
    end
  end

  always_comb begin
    case (state_q)
      ST_AACK, ST_WACK: sda_oe = 1'b1;
      ST_RBYTE:         sda_oe = ~tx_q[7];
      default:          sda_oe = 1'b0;
    endcase
  end

  assign reg_addr  = ptr_q;
  assign reg_wdata = rx_q;

  // R2: a detected STOP parks the machine in idle
  p_stop_to_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state_q == ST_IDLE));

  // R9: a START (first or repeated) restarts address reception, pointer kept
  p_start_restarts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> (state_q == ST_ADDR) && (cnt_q == 4'd0) && (ptr_q == $past(ptr_q)));

  // R4: the address held during an ACK slot is never in the 10-bit prefix range
  p_no_prefix_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_AACK) |-> (rx_q[7:4] != 4'hF));

  // R5: a general-call data byte leaves the pointer untouched
  p_gc_keeps_ptr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gc_q && (state_q == ST_WBYTE) && byte_end && !start_det && !stop_det) |=> (ptr_q == $past(ptr_q)));

  // R6: every register store is followed by a wrapping pointer step
  p_store_steps_ptr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (ptr_q == $past(ptr_q) + 1'b1));

  // R10: the data drive only moves while the synchronised clock line is low
  p_drive_moves_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s);
endmodule

// File: rtl/i2c_ptr_target.sv
module i2c_ptr_target #(
  parameter logic [6:0] DEV_ADDR    = 7'h3A,
  parameter int         NREGS       = 8,
  parameter logic [7:0] RST_BASE    = 8'h50,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  localparam int AW = $clog2(NREGS);

  logic          scl_s;
  logic          sda_s;
  logic          scl_rise;
  logic          scl_fall;
  logic          start_det;
  logic          stop_det;
  logic          reg_we;
  logic [AW-1:0] reg_addr;
  logic [7:0]    reg_wdata;
  logic [7:0]    reg_rdata;

  i2c_tgt_linesync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_tgt_fsm #(
    .DEV_ADDR (DEV_ADDR),
    .AW       (AW)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (reg_rdata),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .sda_oe    (sda_oe_o)
  );

  i2c_tgt_regfile #(
    .NREGS    (NREGS),
    .RST_BASE (RST_BASE)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_we),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata)
  );
endmodule

// File: tb/i2c_ptr_target_bench.sv
module i2c_ptr_target_bench;
  localparam logic [6:0] DEV = 7'h3A;
  localparam int         NR  = 8;

  logic clk;
  logic rst_n;
  logic scl_m;
  logic sda_m;
  logic sda_oe;
  logic sda_line;

  logic  chk_en;
  logic  exp_oe;
  string cur_req;
  int    vecs;
  int    miss;
  bit    done;

  int mem [NR];
  int ptr;
  int mode;   // 0 ignoring, 1 write, 2 general call, 3 read
  bit first;

  assign sda_line = sda_m & ~sda_oe;

  i2c_ptr_target #(
    .DEV_ADDR (DEV),
    .NREGS    (NR)
  ) u_i2c_ptr_target (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_line),
    .sda_oe_o (sda_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always begin
    @(posedge clk);
    #3;
    if (chk_en) begin
      vecs++;
      if (sda_oe !== exp_oe) begin
        miss++;
        $display("FAIL %s: sda_oe=%0b expected %0b at %0t", cur_req, sda_oe, exp_oe, $time);
      end
    end
  end

  task automatic step(input logic scl_v, input logic sda_v, input logic e);
    @(negedge clk);
    scl_m  = scl_v;
    sda_m  = sda_v;
    chk_en = 1'b0;
    exp_oe = e;
    repeat (4) @(negedge clk);
    chk_en = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_bit(input logic b, input logic e);
    step(1'b0, sda_m, e);
    step(1'b0, b, e);
    step(1'b1, b, e);
  endtask

  task automatic bus_start();
    step(1'b0, sda_m, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    mode = 0;
  endtask

  task automatic bus_stop();
    step(1'b0, sda_m, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    mode = 0;
  endtask

  task automatic wr_byte(input logic [7:0] b, input logic ack);
    for (int i = 7; i >= 0; i--) bus_bit(b[i], 1'b0);
    bus_bit(1'b1, ack);
  endtask

  task automatic send_addr(input logic [6:0] a, input logic rw);
    bit hit;
    hit = ((a == DEV) && (a[6:3] != 4'hF)) || ((a == 7'h00) && !rw);
    wr_byte({a, rw}, hit);
    if (!hit)                 mode = 0;
    else if (a == 7'h00)      mode = 2;
    else if (rw)              mode = 3;
    else begin mode = 1; first = 1'b1; end
  endtask

  task automatic send_data(input logic [7:0] b);
    bit ack;
    ack = (mode == 1) || (mode == 2);
    wr_byte(b, ack);
    if (mode == 1) begin
      if (first) begin
        ptr   = b % NR;
        first = 1'b0;
      end else begin
        mem[ptr] = b;
        ptr      = (ptr + 1) % NR;
      end
    end
  endtask

  task automatic get_data(input bit mack);
    logic [7:0] d;
    bit drive;
    drive = (mode == 3);
    d     = drive ? 8'(mem[ptr]) : 8'hFF;
    if (drive) ptr = (ptr + 1) % NR;
    for (int i = 7; i >= 0; i--) bus_bit(1'b1, drive & ~d[i]);
    bus_bit(mack ? 1'b0 : 1'b1, 1'b0);
    if (!mack) mode = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miss++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

  initial begin
    vecs = 0; miss = 0; done = 1'b0;
    for (int i = 0; i < NR; i++) mem[i] = 8'h50 + i;
    ptr = 0; mode = 0; first = 1'b0;
    scl_m = 1'b1; sda_m = 1'b1;
    cur_req = "R1 reset state";
    exp_oe = 1'b0; chk_en = 1'b1;
    rst_n = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R3 R6: matching write, pointer load then two stores
    cur_req = "R3 R6 write with pointer";
    bus_start(); send_addr(DEV, 1'b0);
    send_data(8'h02); send_data(8'h11); send_data(8'h22);
    cur_req = "R2 stop";
    bus_stop();

    // R9 R7 R8 R1: pointer write, repeated START, read three bytes
    cur_req = "R9 repeated start keeps pointer";
    bus_start(); send_addr(DEV, 1'b0); send_data(8'h01);
    bus_start(); send_addr(DEV, 1'b1);
    cur_req = "R7 R10 read data hand-off";
    get_data(1'b1);
    cur_req = "R8 master ack continues";
    get_data(1'b1); get_data(1'b0);
    cur_req = "R8 nack releases bus";
    get_data(1'b0);
    bus_stop();

    // R6: pointer wrap across last register, read back across wrap
    cur_req = "R6 pointer wrap";
    bus_start(); send_addr(DEV, 1'b0);
    send_data(8'h07); send_data(8'hA7); send_data(8'hB0);
    bus_stop();
    bus_start(); send_addr(DEV, 1'b1); get_data(1'b0); bus_stop();
    bus_start(); send_addr(DEV, 1'b0); send_data(8'h06);
    bus_start(); send_addr(DEV, 1'b1);
    get_data(1'b1); get_data(1'b1); get_data(1'b0);
    bus_stop();

    // R3: other address is refused and its bytes get no drive
    cur_req = "R3 address mismatch";
    bus_start(); send_addr(DEV ^ 7'h01, 1'b0); send_data(8'h00); bus_stop();

    // R4: 10-bit prefix range is refused in both directions
    cur_req = "R4 reserved prefix";
    bus_start(); send_addr(7'h7C, 1'b0); send_data(8'h05); bus_stop();
    bus_start(); send_addr(7'h78, 1'b1); get_data(1'b0); bus_stop();

    // R5: general call acknowledged but leaves registers and pointer alone
    cur_req = "R5 general call";
    bus_start(); send_addr(7'h00, 1'b0); send_data(8'h03); send_data(8'h99); bus_stop();
    bus_start(); send_addr(7'h00, 1'b1); bus_stop();
    bus_start(); send_addr(DEV, 1'b1); get_data(1'b0); bus_stop();
    bus_start(); send_addr(DEV, 1'b0); send_data(8'h03);
    bus_start(); send_addr(DEV, 1'b1); get_data(1'b0); bus_stop();

    // R2: after STOP a byte without START is ignored
    cur_req = "R2 no start after stop";
    bus_start(); send_addr(DEV, 1'b0); send_data(8'h04); bus_stop();
    wr_byte({DEV, 1'b0}, 1'b0);
    wr_byte(8'h01, 1'b0);
    bus_start(); send_addr(DEV, 1'b1); get_data(1'b0); bus_stop();

    chk_en = 1'b0;
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule